// File: doc/BRIEF.md
# Parallel LCD Bus Sequencer

This block runs single read or write transfers to an external LCD controller over an 8-bit parallel bus. Each transfer has three timed phases: setup, strobe and hold. Their lengths are set in clock periods by small configuration fields. The strobe style is chosen per transfer:

- Split style: separate active-low read and write strobes.
- Enable style: a read/write level plus an active-high enable pulse.

A register-select line goes out with each transfer. The host raises `req` for one cycle while the block is idle and then waits for the one-cycle `done` pulse.

When busy polling is on, the block does not finish after the transfer. It waits a programmable number of cycles and then reads the controller status with its own register-select level. It tests only the status bits chosen by a mask, at a programmable polarity. It keeps polling, with a programmable gap between polls, until no selected bit is active, and only then reports completion.

When polling is off, the same wait count keeps the block busy after `done`. This spaces out back-to-back transfers. All configuration and request fields are captured when a request is accepted.

Top module: `lcd_bus_if`

## Requirements
- R1: After reset the bus is idle in split style: `lcd_rd_rw`=1, `lcd_wr_e`=1, `lcd_rs`=0, `lcd_d_oe`=0, `lcd_d_out`=0, `done`=0 and `rdata`=0.
- R2: A request accepted at a clock edge starts the setup phase in the next cycle. Setup lasts `cfg_setup_hold`+1 cycles, the strobe phase `cfg_active`+1 cycles and the hold phase `cfg_setup_hold`+1 cycles.
- R3: With `cfg_mode_6800`=0, `lcd_rd_rw` is an active-low read strobe and `lcd_wr_e` is an active-low write strobe. The matching strobe is low only during the strobe phase, and both are high at all other times.
- R4: With `cfg_mode_6800`=1, `lcd_rd_rw` is 0 through setup, strobe and hold of a write and 1 at all other times. `lcd_wr_e` is 1 only during the strobe phase.
- R5: `lcd_d_oe`=1 and `lcd_d_out`=`req_wdata` only in the setup, strobe and hold phases of a write. At all other times `lcd_d_oe`=0 and `lcd_d_out`=0.
- R6: For a read, `rdata` takes `lcd_d_in` at the clock edge that ends the last strobe cycle. Writes and status reads leave `rdata` unchanged.
- R7: With `cfg_busy_en`=0, `done` is 1 for exactly the one cycle after the hold phase. Requests are then ignored for `cfg_wait`+1 cycles, counting the `done` cycle.
- R8: With `cfg_busy_en`=1, the hold phase is followed by `cfg_wait`+1 idle cycles and then status reads with the same phase lengths. `lcd_rs` equals `cfg_busy_rs` from the first status read onward. Before that it holds `req_rs`, and it keeps its last level while idle.
- R9: A status byte counts as busy when any bit set in `cfg_busy_mask` is 1 (`cfg_busy_inv`=0) or 0 (`cfg_busy_inv`=1). A busy status starts another status read. A clear one raises `done` for the one cycle after that hold phase, and in that cycle the block is idle and accepts a new request.
- R10: Between two status reads the bus is idle for `cfg_active`+1 cycles when `cfg_deassert_sel`=1. When it is 0, the gap is (`cfg_setup_hold`+1)+(`cfg_wait`+1) cycles.
- R11: A request raised while a transfer, status poll or recovery is in progress is ignored. Changes to the configuration or request inputs after acceptance have no effect on the transfer under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode_6800 | input | 1 | 1 = enable style, 0 = split strobe style |
| cfg_setup_hold | input | 2 | Setup and hold length minus one |
| cfg_active | input | 4 | Strobe length minus one |
| cfg_wait | input | 2 | Wait or recovery length minus one |
| cfg_deassert_sel | input | 1 | Poll gap source select |
| cfg_busy_en | input | 1 | Enable busy polling |
| cfg_busy_rs | input | 1 | Register-select level during status reads |
| cfg_busy_inv | input | 1 | Busy bits active low when 1 |
| cfg_busy_mask | input | 8 | Status bits tested for busy |
| req | input | 1 | Start a transfer (sampled while idle) |
| req_read | input | 1 | 1 = read, 0 = write |
| req_rs | input | 1 | Register-select level for the transfer |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last read data |
| lcd_rs | output | 1 | Register-select line |
| lcd_rd_rw | output | 1 | Read strobe (split) or R/W level (enable) |
| lcd_wr_e | output | 1 | Write strobe (split) or enable (enable style) |
| lcd_d_out | output | 8 | Data driven to the bus |
| lcd_d_oe | output | 1 | Data output enable |
| lcd_d_in | input | 8 | Data read from the bus |

## Verification
The assertions assume nothing about `lcd_d_in` or the configuration inputs. They rely on `req` arriving in the idle state to start a transfer and on the captured settings staying put until completion. Termination of polling depends on the external controller eventually reporting a clear status. The stimulus therefore returns at most two random, possibly busy, status bytes before it returns a byte whose masked bits are forced inactive. It changes configuration and request inputs to random values in the middle of some transfers, and it raises `req` during activity and recovery to probe R11.

// File: rtl/lcdb_pkg.sv
`timescale 1ns/1ps
package lcdb_pkg;
  parameter int DW  = 8;   // bus data width
  parameter int SHW = 2;   // setup/hold field width
  parameter int ACW = 4;   // strobe field width
  parameter int WSW = 2;   // wait field width

  localparam int ACT_MAX = 1 << ACW;
  localparam int GAP_MAX = (1 << SHW) + (1 << WSW);
  localparam int MAXLEN  = (ACT_MAX > GAP_MAX) ? ACT_MAX : GAP_MAX;
  localparam int CNTW    = $clog2(MAXLEN);

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_ACTIVE, PH_HOLD, PH_WAIT, PH_GAP, PH_RECOVER
  } phase_e;

  typedef struct packed {
    logic           mode_6800;
    logic [SHW-1:0] setup_hold;
    logic [ACW-1:0] act_w;
    logic [WSW-1:0] wait_w;
    logic           deassert_sel;
    logic           busy_en;
    logic           busy_rs;
    logic           busy_inv;
    logic [DW-1:0]  mask;
  } cfg_t;

  function automatic int unsigned setup_len(cfg_t c);
    return 32'(c.setup_hold) + 32'd1;
  endfunction

  function automatic int unsigned active_len(cfg_t c);
    return 32'(c.act_w) + 32'd1;
  endfunction

  function automatic int unsigned wait_len(cfg_t c);
    return 32'(c.wait_w) + 32'd1;
  endfunction

  // idle time between two status reads
  function automatic int unsigned gap_len(cfg_t c);
    return c.deassert_sel ? active_len(c) : setup_len(c) + wait_len(c);
  endfunction

  function automatic logic busy_hit(logic [DW-1:0] status, logic [DW-1:0] mask, logic inv);
    return |((status ^ {DW{inv}}) & mask);
  endfunction
endpackage

// File: rtl/lcdb_timer.sv
`timescale 1ns/1ps
module lcdb_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/lcdb_seq.sv
`timescale 1ns/1ps
module lcdb_seq
  import lcdb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_read,
  input  logic          req_rs,
  input  logic [DW-1:0] req_wdata,
  input  cfg_t          cfg_in,
  input  logic [DW-1:0] d_in,
  output phase_e        phase,
  output logic          rd_flag,
  output logic          mode_q,
  output logic          rs,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          done
);
  phase_e        ph_q, ph_d;
  cfg_t          cfg_q;
  logic          is_read_q, poll_q, rs_q, done_q;
  logic [DW-1:0] wdata_q, rdata_q, status_q;
  logic          last, load;
  logic [CNTW-1:0] load_val;
  int unsigned   len;

  // named events for checks and readability
  wire accept_ev   = (ph_q == PH_IDLE) && req;
  wire cap_ev      = (ph_q == PH_ACTIVE) && last;
  wire cap_main_ev = cap_ev && !poll_q && is_read_q;
  wire cap_poll_ev = cap_ev && poll_q;
  wire hold_end_ev = (ph_q == PH_HOLD) && last;
  wire poll_go_ev  = (ph_q == PH_WAIT) && last;
  wire still_busy  = busy_hit(status_q, cfg_q.mask, cfg_q.busy_inv);
  wire finish_ev   = hold_end_ev && (poll_q ? !still_busy : !cfg_q.busy_en);

  lcdb_timer #(.CW(CNTW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .last(last)
  );

  always_comb begin
    ph_d = ph_q;
    len  = 32'd1;
    unique case (ph_q)
      PH_IDLE:    if (req) begin ph_d = PH_SETUP; len = setup_len(cfg_in); end
      PH_SETUP:   if (last) begin ph_d = PH_ACTIVE; len = active_len(cfg_q); end
      PH_ACTIVE:  if (last) begin ph_d = PH_HOLD; len = setup_len(cfg_q); end
      PH_HOLD: begin
        if (last) begin
          if (poll_q) begin
            if (still_busy) begin ph_d = PH_GAP; len = gap_len(cfg_q); end
            else            ph_d = PH_IDLE;
          end else begin
            ph_d = cfg_q.busy_en ? PH_WAIT : PH_RECOVER;
            len  = wait_len(cfg_q);
          end
        end
      end
      PH_WAIT, PH_GAP: if (last) begin ph_d = PH_SETUP; len = setup_len(cfg_q); end
      PH_RECOVER: if (last) ph_d = PH_IDLE;
      default:    ph_d = PH_IDLE;
    endcase
    load     = (ph_d != ph_q);
    load_val = CNTW'(len - 32'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      cfg_q     <= '0;
      is_read_q <= 1'b0;
      poll_q    <= 1'b0;
      rs_q      <= 1'b0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      status_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= finish_ev;
      if (accept_ev) begin
        cfg_q     <= cfg_in;
        is_read_q <= req_read;
        poll_q    <= 1'b0;
        rs_q      <= req_rs;
        wdata_q   <= req_wdata;
      end
      if (poll_go_ev) begin
        poll_q <= 1'b1;
        rs_q   <= cfg_q.busy_rs;
      end
      if (cap_main_ev) rdata_q  <= d_in;
      if (cap_poll_ev) status_q <= d_in;
    end
  end

  assign phase   = ph_q;
  assign rd_flag = is_read_q | poll_q;
  assign mode_q  = cfg_q.mode_6800;
  assign rs      = rs_q;
  assign wdata   = wdata_q;
  assign rdata   = rdata_q;
  assign done    = done_q;

  // R7: completion is a single-cycle pulse
  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R11: a transfer starts only from idle with a request present
  a_r11_accept_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SETUP && $past(ph_q) == PH_IDLE) |-> $past(req));
  // R6: read data moves only on the main capture edge
  a_r6_rdata_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_q) |-> $past(cap_main_ev));
  // R9: a polled transfer finishes only on a clear status
  a_r9_done_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && poll_q) |-> !busy_hit(status_q, cfg_q.mask, cfg_q.busy_inv));
  // R8: status reads carry the programmed select level
  a_r8_poll_rs_level: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_q && ph_q == PH_SETUP) |-> (rs_q == cfg_q.busy_rs));
endmodule

// File: rtl/lcdb_pins.sv
`timescale 1ns/1ps
module lcdb_pins
  import lcdb_pkg::*;
(
  input  phase_e        phase,
  input  logic          rd_flag,
  input  logic          mode_6800,
  input  logic [DW-1:0] wdata,
  output logic          p_rd_rw,
  output logic          p_wr_e,
  output logic [DW-1:0] d_out,
  output logic          d_oe
);
  logic in_win, strobe;

  always_comb begin
    in_win = (phase == PH_SETUP) || (phase == PH_ACTIVE) || (phase == PH_HOLD);
    strobe = (phase == PH_ACTIVE);
    if (mode_6800) begin
      p_rd_rw = in_win ? rd_flag : 1'b1;
      p_wr_e  = strobe;
    end else begin
      p_rd_rw = !(strobe && rd_flag);
      p_wr_e  = !(strobe && !rd_flag);
    end
    d_oe  = in_win && !rd_flag;
    d_out = d_oe ? wdata : '0;
  end
endmodule

// File: rtl/lcd_bus_if.sv
`timescale 1ns/1ps
module lcd_bus_if
  import lcdb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_mode_6800,
  input  logic [SHW-1:0]       cfg_setup_hold,
  input  logic [ACW-1:0]       cfg_active,
  input  logic [WSW-1:0]       cfg_wait,
  input  logic                 cfg_deassert_sel,
  input  logic                 cfg_busy_en,
  input  logic                 cfg_busy_rs,
  input  logic                 cfg_busy_inv,
  input  logic [DW-1:0]        cfg_busy_mask,
  input  logic                 req,
  input  logic                 req_read,
  input  logic                 req_rs,
  input  logic [DW-1:0]        req_wdata,
  output logic                 done,
  output logic [DW-1:0]        rdata,
  output logic                 lcd_rs,
  output logic                 lcd_rd_rw,
  output logic                 lcd_wr_e,
  output logic [DW-1:0]        lcd_d_out,
  output logic                 lcd_d_oe,
  input  logic [DW-1:0]        lcd_d_in
);
  cfg_t          cfg_in;
  phase_e        phase;
  logic          rd_flag, mode_q;
  logic [DW-1:0] wdata;

  always_comb begin
    cfg_in.mode_6800    = cfg_mode_6800;
    cfg_in.setup_hold   = cfg_setup_hold;
    cfg_in.act_w        = cfg_active;
    cfg_in.wait_w       = cfg_wait;
    cfg_in.deassert_sel = cfg_deassert_sel;
    cfg_in.busy_en      = cfg_busy_en;
    cfg_in.busy_rs      = cfg_busy_rs;
    cfg_in.busy_inv     = cfg_busy_inv;
    cfg_in.mask         = cfg_busy_mask;
  end

  lcdb_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_read(req_read), .req_rs(req_rs),
    .req_wdata(req_wdata), .cfg_in(cfg_in), .d_in(lcd_d_in), .phase(phase),
    .rd_flag(rd_flag), .mode_q(mode_q), .rs(lcd_rs), .wdata(wdata),
    .rdata(rdata), .done(done)
  );

  lcdb_pins u_pins (
    .phase(phase), .rd_flag(rd_flag), .mode_6800(mode_q), .wdata(wdata),
    .p_rd_rw(lcd_rd_rw), .p_wr_e(lcd_wr_e), .d_out(lcd_d_out), .d_oe(lcd_d_oe)
  );

  // R3: split style never asserts both strobes
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (lcd_rd_rw || lcd_wr_e));
  // R5: data is driven only for write transfers
  a_r5_oe_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_d_oe |-> !rd_flag);
  // R4: enable stays low while idle in enable style
  a_r4_enable_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && phase == PH_IDLE) |-> !lcd_wr_e);
endmodule

// File: tb/sim_lcd_bus_if.sv
`timescale 1ns/1ps
module sim_lcd_bus_if;
  import lcdb_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic cfg_mode_6800, cfg_deassert_sel, cfg_busy_en, cfg_busy_rs, cfg_busy_inv;
  logic [SHW-1:0] cfg_setup_hold;
  logic [ACW-1:0] cfg_active;
  logic [WSW-1:0] cfg_wait;
  logic [DW-1:0]  cfg_busy_mask, req_wdata, rdata, lcd_d_out, lcd_d_in;
  logic req, req_read, req_rs, done, lcd_rs, lcd_rd_rw, lcd_wr_e, lcd_d_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit cur_mode, cur_rs;
  logic [DW-1:0] exp_rdata;

  lcd_bus_if u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode_6800(cfg_mode_6800),
    .cfg_setup_hold(cfg_setup_hold), .cfg_active(cfg_active), .cfg_wait(cfg_wait),
    .cfg_deassert_sel(cfg_deassert_sel), .cfg_busy_en(cfg_busy_en),
    .cfg_busy_rs(cfg_busy_rs), .cfg_busy_inv(cfg_busy_inv),
    .cfg_busy_mask(cfg_busy_mask), .req(req), .req_read(req_read), .req_rs(req_rs),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .lcd_rs(lcd_rs),
    .lcd_rd_rw(lcd_rd_rw), .lcd_wr_e(lcd_wr_e), .lcd_d_out(lcd_d_out),
    .lcd_d_oe(lcd_d_oe), .lcd_d_in(lcd_d_in)
  );

  function automatic bit tb_busy(logic [DW-1:0] s, logic [DW-1:0] m, bit inv);
    logic [DW-1:0] act;
    act = inv ? ~s : s;
    return (act & m) != '0;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // kind: 0 idle/gap, 1 setup, 2 strobe, 3 hold
  task automatic sample(input int kind, input bit rd, input bit edone,
                        input logic [DW-1:0] wd, input string tag);
    bit p1, p2, oe;
    logic [DW-1:0] dexp;
    @(negedge clk);
    oe = (kind != 0) && !rd;
    if (cur_mode) begin
      p1 = (kind != 0) ? rd : 1'b1;
      p2 = (kind == 2);
    end else begin
      p1 = !((kind == 2) && rd);
      p2 = !((kind == 2) && !rd);
    end
    dexp = oe ? wd : '0;
    chk(32'({lcd_rd_rw, lcd_wr_e, lcd_d_oe, lcd_rs, done, lcd_d_out}),
        32'({p1, p2, oe, cur_rs, edone, dexp}), tag);
  endtask

  task automatic scramble();
    cfg_mode_6800    = 1'($urandom);
    cfg_setup_hold   = SHW'($urandom);
    cfg_active       = ACW'($urandom);
    cfg_wait         = WSW'($urandom);
    cfg_deassert_sel = 1'($urandom);
    cfg_busy_en      = 1'($urandom);
    cfg_busy_rs      = 1'($urandom);
    cfg_busy_inv     = 1'($urandom);
    cfg_busy_mask    = DW'($urandom);
    req_read         = 1'($urandom);
    req_rs           = 1'($urandom);
    req_wdata        = DW'($urandom);
  endtask

  task automatic bus_cycle(input int s, input int a, input bit rd, input logic [DW-1:0] wd,
                           input logic [DW-1:0] rv, input bit noisy, input string tag);
    for (int i = 0; i < s; i++) begin
      sample(1, rd, 1'b0, wd, tag);
      if (i == 0) begin
        if (noisy) scramble();   // R11: late input changes
        else req = 1'b0;
      end
    end
    for (int i = 0; i < a; i++) begin
      sample(2, rd, 1'b0, wd, tag);
      lcd_d_in = (i == a - 1) ? rv : DW'($urandom);
    end
    for (int i = 0; i < s; i++) begin
      sample(3, rd, 1'b0, wd, tag);
      lcd_d_in = DW'($urandom);
      if (i == s - 1) req = 1'b0;
    end
  endtask

  task automatic run_txn(input bit mode, input logic [SHW-1:0] sh, input logic [ACW-1:0] ac,
                         input logic [WSW-1:0] wt, input bit dsel, input bit ben, input bit brs,
                         input bit binv, input logic [DW-1:0] mask, input bit rd, input bit rs,
                         input logic [DW-1:0] wd, input int kb, input bit noisy);
    int s, a, w, d, polls;
    bit hit;
    logic [DW-1:0] rv, st;
    s = int'(sh) + 1;
    a = int'(ac) + 1;
    w = int'(wt) + 1;
    d = dsel ? a : s + w;
    cfg_mode_6800 = mode; cfg_setup_hold = sh; cfg_active = ac; cfg_wait = wt;
    cfg_deassert_sel = dsel; cfg_busy_en = ben; cfg_busy_rs = brs; cfg_busy_inv = binv;
    cfg_busy_mask = mask; req_read = rd; req_rs = rs; req_wdata = wd; req = 1'b1;
    cur_mode = mode;
    cur_rs   = rs;
    rv = DW'($urandom);
    bus_cycle(s, a, rd, wd, rv, noisy, "R2 R3 R4 R5 R11");
    if (rd) exp_rdata = rv;
    if (!ben) begin
      for (int i = 0; i < w; i++) begin
        sample(0, 1'b1, (i == 0), '0, "R7 R11");
        if (noisy) req = (i != w - 1);
      end
      req = 1'b0;
      sample(0, 1'b1, 1'b0, '0, "R7");
    end else begin
      for (int i = 0; i < w; i++) sample(0, 1'b1, 1'b0, '0, "R8");
      cur_rs = brs;
      polls  = 0;
      do begin
        st = (polls < kb) ? DW'($urandom)
                          : ((DW'($urandom) & ~mask) | (binv ? mask : '0));
        bus_cycle(s, a, 1'b1, '0, st, 1'b0, "R8 R9");
        hit = tb_busy(st, mask, binv);
        polls++;
        if (hit) for (int i = 0; i < d; i++) sample(0, 1'b1, 1'b0, '0, "R10");
      end while (hit);
      sample(0, 1'b1, 1'b1, '0, "R9");
    end
    chk(32'(rdata), 32'(exp_rdata), "R6 rdata");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0;
    cfg_mode_6800 = 0; cfg_setup_hold = '0; cfg_active = '0; cfg_wait = '0;
    cfg_deassert_sel = 0; cfg_busy_en = 0; cfg_busy_rs = 0; cfg_busy_inv = 0;
    cfg_busy_mask = '0; req = 0; req_read = 0; req_rs = 0; req_wdata = '0; lcd_d_in = '0;
    cur_mode = 0; cur_rs = 0; exp_rdata = '0;
    repeat (3) @(negedge clk);
    chk(32'({lcd_rd_rw, lcd_wr_e, lcd_d_oe, lcd_rs, done, lcd_d_out, rdata}),
        32'({1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00}), "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(32'({lcd_rd_rw, lcd_wr_e, lcd_d_oe, lcd_rs, done, lcd_d_out, rdata}),
        32'({1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00}), "R1 after reset");

    // directed corners
    run_txn(0, 2'd0, 4'd0,  2'd0, 0, 0, 0, 0, 8'h80, 0, 1, 8'hA5, 0, 0); // minimum write, split
    run_txn(0, 2'd3, 4'd15, 2'd3, 0, 0, 0, 0, 8'h80, 1, 0, 8'h00, 0, 0); // maximum read, split
    run_txn(1, 2'd1, 4'd2,  2'd1, 0, 0, 0, 0, 8'h80, 0, 1, 8'h3C, 0, 0); // enable-style write
    run_txn(1, 2'd2, 4'd5,  2'd2, 0, 0, 0, 0, 8'h80, 1, 1, 8'h00, 0, 0); // enable-style read
    run_txn(0, 2'd1, 4'd3,  2'd2, 0, 1, 1, 0, 8'h80, 0, 0, 8'h11, 2, 0); // R9 active high, gap S+W
    run_txn(1, 2'd0, 4'd6,  2'd0, 1, 1, 0, 1, 8'h81, 1, 1, 8'h00, 2, 0); // R9 active low, R10 gap=A
    run_txn(0, 2'd2, 4'd1,  2'd3, 1, 1, 1, 0, 8'h00, 0, 1, 8'h5A, 2, 0); // mask zero: single poll
    run_txn(0, 2'd1, 4'd2,  2'd2, 0, 0, 0, 0, 8'h80, 1, 0, 8'h00, 0, 1); // R11 noise, no polling
    run_txn(1, 2'd1, 4'd4,  2'd1, 0, 1, 0, 0, 8'hF0, 0, 1, 8'hC3, 1, 1); // R11 noise, polling

    for (int n = 0; n < 70; n++) begin
      run_txn(1'($urandom), SHW'($urandom), ACW'($urandom), WSW'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              (($urandom % 4) == 0) ? '0 : DW'($urandom),
              1'($urandom), 1'($urandom), DW'($urandom),
              int'($urandom % 3), (($urandom % 5) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule